// File: doc/BRIEF.md
# SPI Slave Register-Access Frontend

This block lets an external SPI master reach a bank of 64 sixteen-bit registers that are held inside the block. Every access is one frame. The frame opens when the active-low chip select falls and closes when it rises. The frame holds three bytes in order: one header byte, then a high payload byte, then a low payload byte.

The header is sent MSB first. Bit 7 selects the direction: 1 is a read and 0 is a write. Bit 6 carries no meaning. Bits 5:0 give the register address. The transfer is half duplex:
- **Write frame:** the payload arrives on MOSI and is written into the bank only when chip select rises.
- **Read frame:** the addressed value is captured at the end of the header and then shifted out on MISO.

SCLK follows mode 0. MOSI is sampled on the rising edge and MISO changes after the falling edge. SCLK, MOSI and chip select pass through two-flop synchronisers into the system clock domain. That clock must run at least four times faster than SCLK.

Host logic in the same clock domain has its own write port into the bank and its own combinational read port.

Top module: `spi_regbank_slave`

## Requirements
- R1: After reset all 64 registers read 0 on the host read port, and MISO is low.
- R2: The header is the first 8 bits, sent MSB first. Bit 7 = 1 means read and bit 7 = 0 means write. Bit 6 is ignored. Bits 5:0 are the register address.
- R3: A write frame with at least 24 rising SCLK edges stores the payload in the addressed register. The payload is bits 9 to 24 of the frame, high byte first, MSB first. The store happens once, after chip select rises, and shows on the host read port within 6 system clocks of that rise.
- R4: A frame that ends with fewer than 24 rising SCLK edges leaves every register unchanged.
- R5: Rising SCLK edges after the 24th are ignored, so the stored value is the first 16 payload bits.
- R6: In a read frame the addressed value is captured when the header completes. Bit 15 is on MISO before the 9th rising edge, and each following bit is on MISO after each falling edge, MSB first.
- R7: A read frame modifies no register.
- R8: MISO is driven low while chip select is high, during the header, and during the payload of a write frame.
- R9: When host_we is high at a clock edge, host_wdata is stored at host_waddr. host_rdata always shows the register at host_raddr with no clock of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock from the master (mode 0) |
| mosi | input | 1 | Serial data from the master |
| cs_n | input | 1 | Active-low frame select |
| miso | output | 1 | Serial data to the master, low when not sending |
| host_we | input | 1 | Host write strobe |
| host_waddr | input | 6 | Host write address |
| host_wdata | input | 16 | Host write data |
| host_raddr | input | 6 | Host read address |
| host_rdata | output | 16 | Register value at host_raddr |

## Verification
The assertions assume the following about the inputs:
- Each SCLK level lasts several system clocks, so every synchronised edge is seen exactly once.
- SCLK is low whenever chip select changes.
- MOSI changes only while SCLK is low.

The stimulus keeps to these limits. It steps each SCLK half period over six system clocks and aligns each step with the falling edge of the system clock. It also waits a half period after chip select falls before the first edge, and after the last falling edge before chip select rises. Under these conditions, the hold check on the host read port relies only on the two write strobes.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 16;
  localparam int HDR_W      = 8;
  localparam int FRAME_BITS = HDR_W + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int DEPTH      = 1 << ADDR_W;

  // Direction flag: MSB of the header, 1 = read.
  function automatic logic hdr_is_read(input logic [HDR_W-1:0] h);
    return h[HDR_W-1];
  endfunction

  // Register address: the low bits of the header.
  function automatic logic [ADDR_W-1:0] hdr_addr(input logic [HDR_W-1:0] h);
    return h[ADDR_W-1:0];
  endfunction

  // True once the edge count has reached the full frame length.
  function automatic logic frame_full(input logic [CNT_W-1:0] c);
    return c == CNT_W'(FRAME_BITS);
  endfunction
endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
  parameter int               WIDTH  = 3,
  parameter int               STAGES = 2,
  parameter logic [WIDTH-1:0] INIT   = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spireg_bank.sv
module spireg_bank
  import spireg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_waddr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [ADDR_W-1:0] host_raddr,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              spi_we,
  input  logic [ADDR_W-1:0] spi_waddr,
  input  logic [DATA_W-1:0] spi_wdata,
  input  logic [ADDR_W-1:0] spi_raddr,
  output logic [DATA_W-1:0] spi_rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // The SPI write is placed last, so it wins when both ports hit one address.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (host_we) mem[host_waddr] <= host_wdata;
      if (spi_we)  mem[spi_waddr]  <= spi_wdata;
    end
  end

  assign host_rdata = mem[host_raddr];
  assign spi_rdata  = mem[spi_raddr];

  // R4 / R7: with no write strobe, the host view of a fixed address stays put.
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_we && !host_we) |=> (!$stable(host_raddr) || $stable(host_rdata)));
endmodule

// File: rtl/spireg_frame.sv
module spireg_frame
  import spireg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic              cs_n_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic              miso
);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic              sclk_d, cs_d;
  logic [CNT_W-1:0]  cnt;
  logic [HDR_W-1:0]  hdr;
  logic [DATA_W-1:0] wsh, rsh;

  // Named events, used by the datapath and by the assertions.
  wire              active    = ~cs_n_s;
  wire              sclk_rise = sclk_s & ~sclk_d;
  wire              sclk_fall = ~sclk_s & sclk_d;
  wire              cs_rise   = cs_n_s & ~cs_d;
  wire              in_hdr    = cnt < CNT_HDR;
  wire              in_pay    = !in_hdr && !frame_full(cnt);
  wire              take      = active && sclk_rise && !frame_full(cnt);
  wire [HDR_W-1:0]  hdr_next  = {hdr[HDR_W-2:0], mosi_s};
  wire              hdr_done  = take && (cnt == CNT_LAST);
  wire              is_rd     = hdr_is_read(hdr);
  wire              shift_out = active && sclk_fall && is_rd && in_pay && (cnt > CNT_HDR);
  wire              drive     = active && is_rd && in_pay;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
      cnt    <= '0;
      hdr    <= '0;
      wsh    <= '0;
      rsh    <= '0;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_n_s;
      if (!active)   cnt <= '0;
      else if (take) cnt <= cnt + CNT_W'(1);
      if (take && in_hdr) hdr <= hdr_next;
      if (take && in_pay) wsh <= {wsh[DATA_W-2:0], mosi_s};
      if (hdr_done)       rsh <= rd_data;
      else if (shift_out) rsh <= {rsh[DATA_W-2:0], 1'b0};
    end
  end

  assign rd_addr = hdr_addr(hdr_next);
  assign we      = cs_rise && frame_full(cnt) && !is_rd;
  assign waddr   = hdr_addr(hdr);
  assign wdata   = wsh;
  assign miso    = drive & rsh[DATA_W-1];

  p_cnt_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_FULL);
  p_cnt_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (cnt == '0));
  p_commit_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> ($past(cnt) == CNT_FULL));
  p_miso_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |-> !miso);
  p_miso_hdr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < CNT_HDR) |-> !miso);
  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && hdr_is_read(hdr_next)) |=> (!active || (miso == $past(rd_data[DATA_W-1]))));
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
  import spireg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              cs_n,
  output logic              miso,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_waddr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [ADDR_W-1:0] host_raddr,
  output logic [DATA_W-1:0] host_rdata
);
  localparam int SYNC_W = 3;

  logic [SYNC_W-1:0] pins_s;
  logic [ADDR_W-1:0] spi_raddr, spi_waddr;
  logic [DATA_W-1:0] spi_rdata, spi_wdata;
  logic              spi_we;

  // Bit order {sclk, mosi, cs_n}; cs_n comes out of reset high.
  spireg_sync #(.WIDTH(SYNC_W), .STAGES(2), .INIT(3'b001)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sclk, mosi, cs_n}),
    .q     (pins_s)
  );

  spireg_frame u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_s  (pins_s[2]),
    .mosi_s  (pins_s[1]),
    .cs_n_s  (pins_s[0]),
    .rd_data (spi_rdata),
    .rd_addr (spi_raddr),
    .we      (spi_we),
    .waddr   (spi_waddr),
    .wdata   (spi_wdata),
    .miso    (miso)
  );

  spireg_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_waddr (host_waddr),
    .host_wdata (host_wdata),
    .host_raddr (host_raddr),
    .host_rdata (host_rdata),
    .spi_we     (spi_we),
    .spi_waddr  (spi_waddr),
    .spi_wdata  (spi_wdata),
    .spi_raddr  (spi_raddr),
    .spi_rdata  (spi_rdata)
  );
endmodule

// File: tb/test_spi_regbank_slave.sv
`timescale 1ns/1ps
module test_spi_regbank_slave;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        mosi = 1'b0;
  logic        cs_n = 1'b1;
  logic        miso;
  logic        host_we = 1'b0;
  logic [5:0]  host_waddr = '0;
  logic [15:0] host_wdata = '0;
  logic [5:0]  host_raddr = '0;
  logic [15:0] host_rdata;

  int errors = 0;
  int checks = 0;

  logic [15:0] exp_q[$];

  always #4 clk = ~clk;

  spi_regbank_slave i_spi_regbank_slave (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso),
    .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: drives one frame of nbits SCLK pulses; header then payload stream, MSB first.
  task automatic spi_frame(input logic [7:0] hdr, input logic [31:0] pay, input int nbits,
                           input logic [15:0] exp_rd);
    logic [39:0] stream;
    stream = {hdr, pay};
    if (hdr[7] && nbits >= 24) exp_q.push_back(exp_rd);
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = stream[39-i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic host_read(input string req, input logic [5:0] a, input logic [15:0] exp);
    @(negedge clk) host_raddr = a;
    #1 chk(req, host_rdata, exp);
  endtask

  task automatic host_write(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_waddr = a; host_wdata = d;
    @(negedge clk) host_we = 1'b0;
  endtask

  // Monitor: samples MISO at each rising SCLK inside a frame.
  int          mon_cnt;
  logic [7:0]  mon_hdr;
  logic [15:0] mon_word;
  logic        mon_loud;

  always @(negedge cs_n) begin
    mon_cnt = 0; mon_hdr = '0; mon_word = '0; mon_loud = 1'b0;
  end

  always @(posedge sclk) begin
    if (!cs_n) begin
      if (mon_cnt < 8) begin
        if (miso !== 1'b0) mon_loud = 1'b1;
        mon_hdr = {mon_hdr[6:0], mosi};
      end else if (mon_cnt < 24) begin
        if (mon_hdr[7]) mon_word = {mon_word[14:0], miso};
        else if (miso !== 1'b0) mon_loud = 1'b1;
      end
      mon_cnt++;
    end
  end

  always @(posedge cs_n) begin
    if (rst_n) begin
      chk("R8 miso quiet in header/write payload", {15'd0, mon_loud}, 16'd0);
      if (mon_hdr[7] && mon_cnt >= 24) begin
        if (exp_q.size() == 0) chk("R6 unexpected read result", mon_word, 16'hxxxx);
        else chk("R6 read data on miso", mon_word, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    host_read("R1 reg0", 6'd0, 16'h0000);
    host_read("R1 reg37", 6'd37, 16'h0000);
    host_read("R1 reg63", 6'd63, 16'h0000);
    chk("R1 miso idle", {15'd0, miso}, 16'd0);
    // R9: host port
    host_write(6'd5, 16'h1234);
    host_read("R9 host write/read", 6'd5, 16'h1234);
    // R3: full write
    spi_frame(8'h0A, {16'hA5C3, 16'h0}, 24, 16'h0);
    host_read("R3 spi write committed", 6'd10, 16'hA5C3);
    // R2: reserved bit 6 ignored
    spi_frame(8'h54, {16'h0F0F, 16'h0}, 24, 16'h0);
    host_read("R2 reserved bit ignored", 6'd20, 16'h0F0F);
    // R4: short frames
    spi_frame(8'h0A, {16'hFFFF, 16'h0}, 23, 16'h0);
    host_read("R4 23 edges no write", 6'd10, 16'hA5C3);
    spi_frame(8'h0A, {16'h0000, 16'h0}, 8, 16'h0);
    host_read("R4 header only no write", 6'd10, 16'hA5C3);
    // R5: extra edges
    spi_frame(8'h3F, {16'h8001, 16'hFF00}, 32, 16'h0);
    host_read("R5 extra edges ignored", 6'd63, 16'h8001);
    // R6 / R7: reads
    spi_frame(8'h85, 32'h0, 24, 16'h1234);
    spi_frame(8'hBF, 32'hFFFF_FFFF, 24, 16'h8001);
    spi_frame(8'h8A, 32'h0, 28, 16'hA5C3);
    spi_frame(8'h80, 32'h0, 24, 16'h0000);
    host_read("R7 read leaves reg5", 6'd5, 16'h1234);
    host_read("R7 read leaves reg63", 6'd63, 16'h8001);
    // R3: overwrite then read back through SPI
    spi_frame(8'h05, {16'h5AA5, 16'h0}, 24, 16'h0);
    spi_frame(8'h85, 32'h0, 24, 16'h5AA5);
    chk("R8 miso low with cs high", {15'd0, miso}, 16'd0);
    chk("R6 all reads returned", 16'(exp_q.size()), 16'd0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule